// File: doc/BRIEF.md
# MDIO Management Bus Master

This block carries single register accesses from an on-chip controller to Ethernet PHY devices over the two-wire management interface. A caller presents a command with an operation flag (read or write), a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block serialises the whole frame, turns the data line around on reads, and collects the PHY's answer. It then signals completion with a single-cycle pulse that carries the read data and an error flag.

The management clock is derived from the system clock. A parameter gives the length of each MDC half period in system cycles. Outgoing bits change only while MDC is low, and each one is held for a full half period before the rising edge. Incoming bits are captured at the very end of the high phase, which leaves the PHY the whole high half to present its data. On a read, the PHY must pull the turnaround slot low. If it does not, the master clocks a fixed drain sequence with the line released and then reports all-ones data with the error flag set.

Top module: `mdio_master`

## Requirements
- R1: Out of reset, and whenever no transaction is in progress, `cmd_ready` is 1, `mdc` is 0, `mdio_oe` is 0 and `done` is 0.
- R2: A command is taken only in a cycle where `cmd_valid` and `cmd_ready` are both 1. `cmd_valid` pulses while busy have no effect on the frame being sent and produce no extra completion. `done` is high for exactly one system cycle per command.
- R3: Every frame opens with 32 bits of value 1 driven with `mdio_oe` = 1, then the start bits 0,1, then the operation bits: 1,0 when `cmd_rd` = 1 and 0,1 when `cmd_rd` = 0. Each bit is the `mdio_o` value seen at an MDC rising edge.
- R4: After the operation bits, the 5-bit PHY address and then the 5-bit register address are driven, each most significant bit first.
- R5: For a write, the turnaround bits 1,0 and then the 16 data bits (MSB first) are driven, which makes 64 driven bits. One further MDC cycle follows with `mdio_oe` = 0, for 65 rising edges in total, and then `done` pulses with `err` = 0.
- R6: For a read, `mdio_oe` goes to 0 after the 46th bit. The 47th bit is the turnaround, sampled from `mdio_i`. When it is 0, 16 bits are sampled MSB first, one more released MDC cycle follows (64 rising edges in total), and `rd_data` shows the sampled word with `err` = 0.
- R7: When the sampled read turnaround is 1, the master clocks 32 further released MDC cycles (79 rising edges in total) and completes with `rd_data` = 16'hFFFF and `err` = 1.
- R8: `err` returns to 0 when the next command is accepted.
- R9: MDC stays high for exactly HALF_CYC system cycles and low for at least HALF_CYC system cycles. `mdio_o` and `mdio_oe` do not change while MDC is high. `mdio_i` is sampled in the last system cycle of the high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle; a command is accepted when high |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_phy | input | 5 | PHY address |
| cmd_regad | input | 5 | Register address inside the PHY |
| cmd_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid with `done` after a read |
| err | output | 1 | Read turnaround failure, valid with `done` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for the data line |
| mdio_i | input | 1 | Serial data in |

## Verification
A wrong bit counter or a stuck state shows at the line within one MDC period. It appears as a misplaced start or operation bit, an address off by one position, or a rising-edge count per transaction other than 65, 64 or 79. A wrong turnaround decision appears at the `done` pulse as a wrong `err` or a `rd_data` that is not all ones. A sampling point moved to the rising edge returns the previous bit of the PHY's word, because the PHY model changes `mdio_i` only after each rising edge. Divider faults show as a high phase that is not HALF_CYC cycles long, or as data moving while MDC is high, and the checker flags these on the first wrong edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEND,
      ST_TURN,
      ST_RECV,
      ST_FLUSH,
      ST_TAIL
   } mdio_state_e;

   localparam logic [1:0] START_BITS = 2'b01;
   localparam logic [1:0] OP_READ    = 2'b10;
   localparam logic [1:0] OP_WRITE   = 2'b01;
   localparam logic [1:0] WR_TURN    = 2'b10;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int HALF_CYC = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic mdc,
   output logic bit_end
);
   generate
      if (HALF_CYC < 1) begin : g_bad_half
         $error("mdio_mdc_gen: HALF_CYC must be at least 1");
      end

      if (HALF_CYC == 1) begin : g_fast
         always_ff @(posedge clk) begin
            if (!rst_n || !en) mdc <= 1'b0;
            else               mdc <= ~mdc;
         end
         assign bit_end = en & mdc;
      end else begin : g_count
         localparam int CW = $clog2(HALF_CYC);
         logic [CW-1:0] cnt;
         logic          last;
         assign last = (cnt == CW'(HALF_CYC - 1));

         always_ff @(posedge clk) begin
            if (!rst_n || !en) begin
               cnt <= '0;
               mdc <= 1'b0;
            end else if (last) begin
               cnt <= '0;
               mdc <= ~mdc;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         assign bit_end = en & mdc & last;
      end
   endgenerate
endmodule

// File: rtl/mdio_shift_out.sv
module mdio_shift_out #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   output logic         msb
);
   generate
      if (W < 2) begin : g_bad_w
         $error("mdio_shift_out: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] sr;

   always_ff @(posedge clk) begin
      if (!rst_n)     sr <= '0;
      else if (load)  sr <= load_val;
      else if (shift) sr <= {sr[W-2:0], 1'b0};
   end

   assign msb = sr[W-1];
endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int HALF_CYC  = 10,
   parameter int PRE_LEN   = 32,
   parameter int FLUSH_LEN = 32,
   parameter int AW        = 5,
   parameter int DW        = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   output logic          cmd_ready,
   input  logic          cmd_rd,
   input  logic [AW-1:0] cmd_phy,
   input  logic [AW-1:0] cmd_regad,
   input  logic [DW-1:0] cmd_wdata,
   output logic          done,
   output logic [DW-1:0] rd_data,
   output logic          err,
   output logic          mdc,
   output logic          mdio_o,
   output logic          mdio_oe,
   input  logic          mdio_i
);
   localparam int HDR_LEN = PRE_LEN + 4 + 2 * AW;
   localparam int WR_LEN  = HDR_LEN + 2 + DW;
   localparam int MAX_LEN = (WR_LEN > FLUSH_LEN) ? WR_LEN : FLUSH_LEN;
   localparam int CNT_W   = $clog2(MAX_LEN + 1);

   generate
      if (PRE_LEN < 1)   begin : g_bad_pre   $error("mdio_master: PRE_LEN must be at least 1");   end
      if (FLUSH_LEN < 1) begin : g_bad_flush $error("mdio_master: FLUSH_LEN must be at least 1"); end
      if (AW < 1)        begin : g_bad_aw    $error("mdio_master: AW must be at least 1");        end
      if (DW < 2)        begin : g_bad_dw    $error("mdio_master: DW must be at least 2");        end
   endgenerate

   mdio_state_e      state;
   logic [CNT_W-1:0] cnt;
   logic             is_rd;
   logic             oe_q;
   logic [DW-1:0]    rx;
   logic             bit_end;
   logic             tx_bit;
   logic             accept;
   logic             shift_en;
   logic [WR_LEN-1:0] frame;

   assign cmd_ready = (state == ST_IDLE);
   assign accept    = cmd_valid & cmd_ready;
   assign shift_en  = (state == ST_SEND) & bit_end & (cnt != '0);
   assign frame     = {{PRE_LEN{1'b1}}, START_BITS, (cmd_rd ? OP_READ : OP_WRITE),
                       cmd_phy, cmd_regad, WR_TURN, cmd_wdata};

   mdio_mdc_gen #(.HALF_CYC(HALF_CYC)) u_mdc (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (state != ST_IDLE),
      .mdc     (mdc),
      .bit_end (bit_end)
   );

   mdio_shift_out #(.W(WR_LEN)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (frame),
      .shift    (shift_en),
      .msb      (tx_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         is_rd   <= 1'b0;
         oe_q    <= 1'b0;
         rx      <= '0;
         rd_data <= '0;
         err     <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  state <= ST_SEND;
                  is_rd <= cmd_rd;
                  cnt   <= cmd_rd ? CNT_W'(HDR_LEN - 1) : CNT_W'(WR_LEN - 1);
                  oe_q  <= 1'b1;
                  err   <= 1'b0;
               end
            end
            ST_SEND: begin
               if (bit_end) begin
                  if (cnt == '0) begin
                     oe_q  <= 1'b0;
                     state <= is_rd ? ST_TURN : ST_TAIL;
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
            end
            ST_TURN: begin
               if (bit_end) begin
                  if (!mdio_i) begin
                     state <= ST_RECV;
                     cnt   <= CNT_W'(DW - 1);
                  end else begin
                     state <= ST_FLUSH;
                     cnt   <= CNT_W'(FLUSH_LEN - 1);
                  end
               end
            end
            ST_RECV: begin
               if (bit_end) begin
                  rx <= {rx[DW-2:0], mdio_i};
                  if (cnt == '0) state <= ST_TAIL;
                  else           cnt   <= cnt - 1'b1;
               end
            end
            ST_FLUSH: begin
               if (bit_end) begin
                  if (cnt == '0) begin
                     rd_data <= '1;
                     err     <= 1'b1;
                     done    <= 1'b1;
                     state   <= ST_IDLE;
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
            end
            ST_TAIL: begin
               if (bit_end) begin
                  if (is_rd) rd_data <= rx;
                  done  <= 1'b1;
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign mdio_oe = oe_q;
   assign mdio_o  = oe_q & tx_bit;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
   parameter int HALF_CYC = 10,
   parameter int DW       = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_ready,
   input logic          done,
   input logic          err,
   input logic          mdc,
   input logic          mdio_o,
   input logic          mdio_oe,
   input logic [DW-1:0] rd_data
);
   localparam int HW = $clog2(HALF_CYC + 2) + 1;

   logic          mdc_q;
   logic [HW-1:0] hcnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mdc_q <= 1'b0;
         hcnt  <= '0;
      end else begin
         mdc_q <= mdc;
         if (mdc != mdc_q)                     hcnt <= HW'(1);
         else if (hcnt != HW'(HALF_CYC + 1))   hcnt <= hcnt + 1'b1;
      end
   end

   // R1
   idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (!mdc && !mdio_oe));

   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cmd_ready);

   // R7
   err_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> (rd_data == '1));

   // R9
   hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

   // R9
   high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mdc && mdc_q) |-> (hcnt == HW'(HALF_CYC)));

   // R9
   low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && !mdc_q) |-> (hcnt >= HW'(HALF_CYC)));
endmodule

bind mdio_master mdio_master_chk #(.HALF_CYC(HALF_CYC), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_ready (cmd_ready),
   .done      (done),
   .err       (err),
   .mdc       (mdc),
   .mdio_o    (mdio_o),
   .mdio_oe   (mdio_oe),
   .rd_data   (rd_data)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 3;
   localparam int HDR        = 46;

   typedef struct {
      logic        rd;
      logic [4:0]  phy;
      logic [4:0]  rg;
      logic [15:0] wd;
      logic [15:0] rdata;
      logic        err;
      int          rises;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmd_valid, cmd_rd;
   logic [4:0]  cmd_phy, cmd_regad;
   logic [15:0] cmd_wdata;
   logic        cmd_ready, done, err, mdc, mdio_o, mdio_oe, mdio_i;
   logic [15:0] rd_data;

   int   n_chk = 0, n_fail = 0;
   exp_t q[$];
   int   rise_cnt = 0;
   logic cap_o [0:127];
   logic cap_oe[0:127];
   logic mdc_p = 1'b0, done_p = 1'b0, o_p = 1'b0;
   logic timing_bad = 1'b0;
   int   hi_len = 0;
   logic closed = 1'b0;
   logic m_ta_ok = 1'b1;
   logic [15:0] m_pdata = '0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   mdio_master #(.HALF_CYC(HALF)) u_mdio_master (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_rd(cmd_rd), .cmd_phy(cmd_phy), .cmd_regad(cmd_regad), .cmd_wdata(cmd_wdata),
      .done(done), .rd_data(rd_data), .err(err), .mdc(mdc), .mdio_o(mdio_o),
      .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // PHY model: presents bit k only after the k-th rising edge (idle line reads 1)
   function automatic logic phy_bit(input int rises);
      int idx;
      idx = rises - 1;
      if (idx == HDR) return !m_ta_ok;
      if (m_ta_ok && idx > HDR && idx <= HDR + 16) return m_pdata[HDR + 16 - idx];
      return 1'b1;
   endfunction
   assign mdio_i = phy_bit(rise_cnt);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (mdc && !mdc_p) begin
            if (rise_cnt < 128) begin
               cap_o[rise_cnt]  = mdio_o;
               cap_oe[rise_cnt] = mdio_oe;
            end
            rise_cnt++;
            hi_len = 1;
         end else if (mdc) begin
            hi_len++;
            if (mdio_o != o_p) timing_bad = 1'b1;
         end else if (mdc_p && hi_len != HALF) begin
            timing_bad = 1'b1;
         end
         if (done && done_p) chk(1'b0, "R2", "done longer than one cycle", 2, 1);
         if (done) begin
            if (q.size() == 0) begin
               chk(1'b0, "R2", "unexpected completion", 1, 0);
            end else begin
               exp_t e;
               logic [63:0] fr;
               int nd, bad_pre, bad_op, bad_adr, bad_tail, bad_rel;
               e = q.pop_front();
               fr = {32'hFFFF_FFFF, 2'b01, (e.rd ? 2'b10 : 2'b01), e.phy, e.rg, 2'b10, e.wd};
               nd = e.rd ? HDR : 64;
               bad_pre = 0; bad_op = 0; bad_adr = 0; bad_tail = 0; bad_rel = 0;
               for (int k = 0; k < nd; k++) begin
                  if (cap_oe[k] !== 1'b1 || cap_o[k] !== fr[63-k]) begin
                     if (k < 32)      bad_pre++;
                     else if (k < 36) bad_op++;
                     else if (k < 46) bad_adr++;
                     else             bad_tail++;
                  end
               end
               for (int k = nd; k < e.rises && k < 128; k++)
                  if (cap_oe[k] !== 1'b0) bad_rel++;
               chk(bad_pre == 0, "R3", "preamble bits wrong", 64'(bad_pre), 0);
               chk(bad_op == 0, "R3", "start/op bits wrong", 64'(bad_op), 0);
               chk(bad_adr == 0, "R4", "address bits wrong", 64'(bad_adr), 0);
               if (!e.rd) chk(bad_tail == 0, "R5", "write turnaround/data wrong", 64'(bad_tail), 0);
               chk(bad_rel == 0, e.rd ? "R6" : "R5", "line not released", 64'(bad_rel), 0);
               chk(rise_cnt == e.rises, e.err ? "R7" : (e.rd ? "R6" : "R5"),
                   "MDC rising edges", 64'(rise_cnt), 64'(e.rises));
               chk(err === e.err, e.err ? "R7" : "R8", "err flag", 64'(err), 64'(e.err));
               if (e.rd) chk(rd_data === e.rdata, e.err ? "R7" : "R6", "read data",
                             64'(rd_data), 64'(e.rdata));
               chk(!timing_bad, "R9", "MDC phase length or data moved while high",
                   64'(timing_bad), 0);
               chk(cmd_ready && !mdc && !mdio_oe, "R1", "idle lines after completion",
                   {61'b0, cmd_ready, mdc, mdio_oe}, 64'b100);
            end
            closed = 1'b1;
         end
      end
      mdc_p  = mdc;
      done_p = done;
      o_p    = mdio_o;
   end

   task automatic run_txn(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] wd, input logic ta_ok, input logic [15:0] pdata,
                          input bit poke);
      exp_t e;
      while (!cmd_ready) @(negedge clk);
      m_ta_ok = ta_ok;
      m_pdata = pdata;
      e.rd = rd; e.phy = phy; e.rg = rg; e.wd = wd;
      e.err = rd && !ta_ok;
      e.rdata = !rd ? 16'h0 : (ta_ok ? pdata : 16'hFFFF);
      e.rises = !rd ? 65 : (ta_ok ? 64 : 79);
      q.push_back(e);
      rise_cnt = 0;
      timing_bad = 1'b0;
      closed = 1'b0;
      cmd_valid = 1'b1; cmd_rd = rd; cmd_phy = phy; cmd_regad = rg; cmd_wdata = wd;
      @(negedge clk);
      cmd_valid = 1'b0;
      if (poke) begin
         repeat (40) @(negedge clk);
         // R2: request while busy with different fields must be ignored
         cmd_valid = 1'b1; cmd_rd = ~rd; cmd_phy = ~phy; cmd_regad = ~rg; cmd_wdata = ~wd;
         @(negedge clk);
         cmd_valid = 1'b0;
      end
      while (!closed) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      cmd_valid = 1'b0; cmd_rd = 1'b0; cmd_phy = '0; cmd_regad = '0; cmd_wdata = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R1 reset state
      chk(cmd_ready && !mdc && !mdio_oe && !done, "R1", "reset state",
          {60'b0, cmd_ready, mdc, mdio_oe, done}, 64'b1000);

      run_txn(1'b0, 5'h01, 5'h1F, 16'hA55A, 1'b1, 16'h0, 1'b0);   // R5 write
      run_txn(1'b0, 5'h1E, 5'h00, 16'h0001, 1'b1, 16'h0, 1'b1);   // R2 poke while busy
      run_txn(1'b1, 5'h11, 5'h02, 16'h0, 1'b1, 16'hC35A, 1'b0);   // R6 read
      run_txn(1'b1, 5'h05, 5'h0A, 16'h0, 1'b0, 16'h1234, 1'b0);   // R7 bad turnaround
      run_txn(1'b1, 5'h05, 5'h0A, 16'h0, 1'b1, 16'h0000, 1'b0);   // R8 err cleared
      run_txn(1'b1, 5'h00, 5'h15, 16'h0, 1'b0, 16'h0, 1'b1);      // R7 again, with poke
      run_txn(1'b0, 5'h0A, 5'h15, 16'hFFFF, 1'b1, 16'h0, 1'b0);   // R8 write after error
      run_txn(1'b1, 5'h1F, 5'h1F, 16'h0, 1'b1, 16'hFFFF, 1'b0);   // R6 all ones data
      run_txn(1'b1, 5'h10, 5'h01, 16'h0, 1'b1, 16'h8001, 1'b0);   // R6 edge bits

      chk(q.size() == 0, "R2", "completions outstanding", 64'(q.size()), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule